// File: doc/BRIEF.md
# Windowed Command Slot Limiter

This block sits in front of a memory command bus. It caps how much command-bus time can be spent in each fixed window, where one window lasts as long as one data burst transfer. A free-running timer divides time into windows. For each of a small set of upcoming windows, the block keeps a record of how many command slots have already been booked. A window that closes is released, and its storage is reused as the farthest future window.

A requester offers one command at a time with a valid/ready handshake. Each command names the window it wants, as an offset from the current window, and says whether it is a single-cycle or a two-cycle command. The block grants the command in the nearest window at or after the requested one that still has room for it. The grant comes in the same cycle as the request, together with the final window offset. When none of the tracked windows from the requested offset onward has room, ready is held low. The command stays with the requester until a window boundary frees space.

Top module: `cmd_window_limiter`

## Requirements
- R1: Window boundaries fall every WIN_CYCLES clock cycles. The first window covers the WIN_CYCLES cycles that start with the first cycle after reset is released. At each boundary every offset moves one step closer, so a booking at offset k is seen at offset k-1 in the next window.
- R2: No window is ever booked beyond SLOTS_PER_WIN slots.
- R3: A command with `req_dual`=0 uses one slot, and a command with `req_dual`=1 uses two slots of its window.
- R4: A command is granted in the lowest window offset that is at least `req_win_ofs` and still has room for its cost. If the requested window is full, the command moves to the next window, and this repeats until a window with room is found.
- R5: `gnt_valid` is high exactly in the cycles where `req_valid` and `req_ready` are both high. In those cycles `gnt_win_ofs` carries the granted offset; otherwise `gnt_win_ofs` is 0.
- R6: When no window from `req_win_ofs` to NUM_WIN-1 has room for the command, `req_ready` is low and the booking state is left unchanged.
- R7: The window that comes into view at offset NUM_WIN-1 after a boundary is empty.
- R8: After reset every tracked window is empty, so any first request is granted at exactly its requested offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is offered |
| req_ready | output | 1 | The offered command fits in some window at or after the requested one |
| req_win_ofs | input | $clog2(NUM_WIN) | Desired window, as an offset from the current window |
| req_dual | input | 1 | 1 = two-cycle command (two slots), 0 = single-cycle command (one slot) |
| gnt_valid | output | 1 | The command is accepted this cycle |
| gnt_win_ofs | output | $clog2(NUM_WIN) | Window offset the command was granted in |

## Verification
Ready, grant valid and the granted offset depend combinationally on the inputs of the same cycle. A booking made in one cycle first changes the search result in the cycle after it. The bench therefore drives the inputs just after a rising edge and compares all three outputs at the following falling edge. It then advances its own window list by one clock. The window-boundary shift is applied at the end of every WIN_CYCLES-th cycle after reset, counted from the first cycle with reset low. A stalled offer is followed in later cycles, so the bench can see that it was not booked.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Kind of command offered to the limiter.
    typedef enum logic {
        CMD_SINGLE = 1'b0,
        CMD_DUAL   = 1'b1
    } cmd_kind_e;

    // Slot cost of a command within its window.
    function automatic logic [1:0] slot_cost(input cmd_kind_e kind);
        return (kind == CMD_DUAL) ? 2'd2 : 2'd1;
    endfunction

    // Result of the free-window search.
    typedef struct packed {
        logic       hit;
        logic [7:0] ofs;
    } search_res_t;

endpackage

// File: rtl/wcs_window_timer.sv
module wcs_window_timer #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int PH_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WIN_CYCLES - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign win_end = (phase_q == PH_LAST);

    AST_WINDOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (phase_q == '0)); // R1

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(phase_q) < WIN_CYCLES); // R1

endmodule

// File: rtl/wcs_occ_ring.sv
module wcs_occ_ring #(
    parameter int NUM_WIN       = 8,
    parameter int SLOTS_PER_WIN = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       win_end,
    input  logic                       book_valid,
    input  logic [$clog2(NUM_WIN)-1:0] book_ofs,
    input  logic [1:0]                 book_cost,
    output logic [$clog2(SLOTS_PER_WIN+1)-1:0] occ_view [NUM_WIN]
);
    localparam int OFS_W = $clog2(NUM_WIN);
    localparam int OCC_W = $clog2(SLOTS_PER_WIN + 1);

    logic [OFS_W-1:0] head_q;
    logic [OCC_W-1:0] occ_phys [NUM_WIN];

    // Head points at the physical entry of the current window.
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else if (win_end) begin
            head_q <= head_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
        logic [OCC_W-1:0] cnt_q;
        logic [OFS_W-1:0] logical;

        assign logical = OFS_W'(i) - head_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (win_end && (head_q == OFS_W'(i))) begin
                cnt_q <= '0;
            end else if (book_valid && (book_ofs == logical)) begin
                cnt_q <= cnt_q + OCC_W'(book_cost);
            end
        end

        assign occ_phys[i] = cnt_q;

        AST_OCC_WITHIN_CAP: assert property (@(posedge clk) disable iff (rst)
            int'(cnt_q) <= SLOTS_PER_WIN); // R2
    end

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_view
        assign occ_view[k] = occ_phys[OFS_W'(head_q + OFS_W'(k))];
    end

    AST_FRESH_WINDOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (occ_view[NUM_WIN-1] == '0)); // R7

endmodule

// File: rtl/wcs_slot_search.sv
module wcs_slot_search
    import wcs_pkg::*;
#(
    parameter int NUM_WIN       = 8,
    parameter int SLOTS_PER_WIN = 2
) (
    input  logic [$clog2(SLOTS_PER_WIN+1)-1:0] occ_view [NUM_WIN],
    input  logic [$clog2(NUM_WIN)-1:0]         start_ofs,
    input  logic [1:0]                         cost,
    output logic                               found,
    output logic [$clog2(NUM_WIN)-1:0]         sel_ofs
);
    localparam int OFS_W = $clog2(NUM_WIN);

    search_res_t res;

    // First fit: scanning downward leaves the lowest qualifying offset.
    always_comb begin
        res = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if ((k >= int'(start_ofs)) &&
                (int'(occ_view[k]) + int'(cost) <= SLOTS_PER_WIN)) begin
                res.hit = 1'b1;
                res.ofs = 8'(k);
            end
        end
    end

    assign found   = res.hit;
    assign sel_ofs = OFS_W'(res.ofs);

endmodule

// File: rtl/cmd_window_limiter.sv
module cmd_window_limiter
    import wcs_pkg::*;
#(
    parameter int WIN_CYCLES    = 4,
    parameter int SLOTS_PER_WIN = 2,
    parameter int NUM_WIN       = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(NUM_WIN)-1:0] req_win_ofs,
    input  logic                       req_dual,
    output logic                       gnt_valid,
    output logic [$clog2(NUM_WIN)-1:0] gnt_win_ofs
);
    localparam int OFS_W = $clog2(NUM_WIN);
    localparam int OCC_W = $clog2(SLOTS_PER_WIN + 1);

    logic             win_end;
    logic [1:0]       cost;
    logic             found;
    logic [OFS_W-1:0] sel_ofs;
    logic [OCC_W-1:0] occ_view [NUM_WIN];

    assign cost = slot_cost(cmd_kind_e'(req_dual));

    wcs_window_timer #(
        .WIN_CYCLES(WIN_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .win_end (win_end)
    );

    wcs_occ_ring #(
        .NUM_WIN       (NUM_WIN),
        .SLOTS_PER_WIN (SLOTS_PER_WIN)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .win_end    (win_end),
        .book_valid (gnt_valid),
        .book_ofs   (sel_ofs),
        .book_cost  (cost),
        .occ_view   (occ_view)
    );

    wcs_slot_search #(
        .NUM_WIN       (NUM_WIN),
        .SLOTS_PER_WIN (SLOTS_PER_WIN)
    ) u_search (
        .occ_view  (occ_view),
        .start_ofs (req_win_ofs),
        .cost      (cost),
        .found     (found),
        .sel_ofs   (sel_ofs)
    );

    assign req_ready   = found;
    assign gnt_valid   = req_valid && found;
    assign gnt_win_ofs = gnt_valid ? sel_ofs : '0;

    AST_GRANT_FITS: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (int'(occ_view[gnt_win_ofs]) + int'(cost) <= SLOTS_PER_WIN)); // R3

    AST_NEVER_EARLY: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (gnt_win_ofs >= req_win_ofs)); // R4

    AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |->
            (int'(occ_view[NUM_WIN-1]) + int'(cost) > SLOTS_PER_WIN)); // R6

    AST_IDLE_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !gnt_valid |-> (gnt_win_ofs == '0)); // R5

endmodule

// File: tb/cmd_window_limiter_bench.sv
`timescale 1ns/1ps
module cmd_window_limiter_bench;
    localparam int W   = 4;
    localparam int CAP = 2;
    localparam int N   = 8;
    localparam int OW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [OW-1:0] req_win_ofs = '0;
    logic          req_dual = 1'b0;
    logic          gnt_valid;
    logic [OW-1:0] gnt_win_ofs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model: booked slots per upcoming window, plus the cycle position in the window.
    int occ[$];
    int phase;

    always #2.5 clk = ~clk;

    cmd_window_limiter #(
        .WIN_CYCLES(W), .SLOTS_PER_WIN(CAP), .NUM_WIN(N)
    ) u_cmd_window_limiter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_win_ofs(req_win_ofs), .req_dual(req_dual),
        .gnt_valid(gnt_valid), .gnt_win_ofs(gnt_win_ofs)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        occ.delete();
        for (int i = 0; i < N; i++) occ.push_back(0);
        phase = 0;
    endtask

    // One cycle: drive, compare at the falling edge, advance the model.
    task automatic step(input bit v, input int ofs, input bit dual, input string tag);
        int  cost;
        int  sel;
        bit  fit;
        req_valid   = v;
        req_win_ofs = OW'(ofs);
        req_dual    = dual;
        cost = dual ? 2 : 1;
        fit  = 1'b0;
        sel  = 0;
        for (int k = N - 1; k >= ofs; k--) begin
            if (occ[k] + cost <= CAP) begin
                fit = 1'b1;
                sel = k;
            end
        end
        @(negedge clk);
        check(tag, int'(req_ready), int'(fit), "req_ready");
        check(tag, int'(gnt_valid), int'(v && fit), "gnt_valid");
        check(tag, int'(gnt_win_ofs), (v && fit) ? sel : 0, "gnt_win_ofs");
        if (v && fit) occ[sel] = occ[sel] + cost;
        if (phase == W - 1) begin
            void'(occ.pop_front());
            occ.push_back(0);
            phase = 0;
        end else begin
            phase++;
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        bit [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R8: empty after reset; first request lands where asked
        step(1'b0, 0, 1'b0, "R8");
        step(1'b1, 3, 1'b1, "R8");

        // R5: idle cycles keep grant low and offset zero
        step(1'b0, 5, 1'b0, "R5");
        step(1'b0, 2, 1'b1, "R5");

        // R4 and R1: stream of single commands into the current window defers forward, boundaries shift offsets
        for (int i = 0; i < 12; i++) step(1'b1, 0, 1'b0, "R4");
        for (int i = 0; i < 9; i++) step(1'b1, 1, 1'b0, "R1");

        // R3: two-slot commands mixed with single ones
        for (int i = 0; i < 10; i++) step(1'b1, 2, i[0], "R3");

        // R6 and R7: hammer the farthest window with two-slot commands
        for (int i = 0; i < 16; i++) step(1'b1, N - 1, 1'b1, "R6");
        for (int i = 0; i < 8; i++) step(1'b1, N - 1, 1'b0, "R7");

        // R2: pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], int'(lfsr[4:2]), lfsr[5] & lfsr[6], "R2");
        end

        // R8 again: a fresh reset empties every window
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
        step(1'b1, 0, 1'b1, "R8");
        step(1'b1, N - 1, 1'b1, "R8");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule